// File: doc/BRIEF.md
# Warp Memory Address Coalescer

This block takes one warp's load: a byte address for every lane, an active-lane mask and a warp identifier. It sorts the active addresses by cache line and emits one request per distinct line. Each request carries the line address, the warp identifier and a lane mask showing which threads the line serves, so a later stage can merge it with requests from other warps. A load that touches several lines stays in the block and drains one line per cycle until every active lane has been served.

Both sides use valid/ready. On the input side, `in_ready` is high only when no warp is held, or when the last line of the held warp leaves in that same cycle, so a new warp can follow with no bubble. The caller must hold its inputs steady while `in_valid` is high and `in_ready` is low. On the output side, a request stays unchanged while `out_ready` is low. A transfer happens on any clock edge where valid and ready are both high.

Top module: `warp_line_coalescer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The line address is the byte address with its low log2(LINE_BYTES) bits dropped. With the default parameters this is bits 31:7. Lane i's address sits at `in_addr[i*ADDR_W +: ADDR_W]`.
- R3: Each request's lane mask holds the lowest-numbered lane that is still unserved, together with every other unserved active lane whose address falls in that same line.
- R4: The requests of one warp have disjoint, non-empty lane masks. Their union equals the active mask, and one request is emitted per distinct line.
- R5: `out_wid` equals the warp identifier that was captured with the warp.
- R6: `out_valid` rises in the cycle after a warp with a non-zero mask is accepted. At most one request is presented per cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_line`, `out_lanes` and `out_wid` hold their values.
- R8: `in_ready` is low while a warp is still being drained. The only exception is the cycle in which its last line is taken with `out_ready` high; in that cycle a new warp can be accepted.
- R9: A warp with an all-zero mask is accepted and produces no request.
- R10: Addresses on inactive lanes have no effect on any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A warp load is offered |
| in_ready | output | 1 | The block can take a warp this cycle |
| in_wid | input | WID_W | Warp identifier |
| in_mask | input | LANES | Active-lane mask |
| in_addr | input | LANES*ADDR_W | Per-lane byte addresses, lane 0 in the low bits |
| out_valid | output | 1 | A line request is presented |
| out_ready | input | 1 | The downstream stage takes the request |
| out_line | output | ADDR_W-log2(LINE_BYTES) | Cache-line address |
| out_wid | output | WID_W | Warp identifier of the request |
| out_lanes | output | LANES | Lanes served by this line |

## Verification
The assertions assume the caller does not change a warp it is offering before that warp is accepted, and that reset is held for at least one edge. Under those conditions the stability and disjointness properties depend only on the block's own state. The bench only raises `in_valid` when it expects `in_ready` to be high, and it drops `in_valid` right after the accepting edge, so it never offers a warp that could be refused. The bench drives `out_ready` with a pseudo-random pattern to exercise stalls while keeping to the handshake rules.

// File: rtl/wlc_pkg.sv
package wlc_pkg;
  // Classification of the held warp for the current cycle.
  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,  // nothing held
    STEP_MORE = 2'd1,  // lines remain after the presented one
    STEP_LAST = 2'd2   // presented line finishes the warp
  } wlc_step_e;
endpackage

// File: rtl/wlc_leader.sv
// Picks the lowest-numbered unserved lane as a one-hot vector.
module wlc_leader #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] pending,
  output logic [LANES-1:0] lead_oh
);
  logic seen;
  always_comb begin
    seen    = 1'b0;
    lead_oh = '0;
    for (int i = 0; i < LANES; i++) begin
      lead_oh[i] = pending[i] & ~seen;
      seen       = seen | pending[i];
    end
  end
endmodule

// File: rtl/wlc_line_cmp.sv
// Selects the leader's line tag and flags every pending lane on that line.
module wlc_line_cmp #(
  parameter int LANES = 32,
  parameter int TAG_W = 25
) (
  input  logic [LANES*TAG_W-1:0] tags,
  input  logic [LANES-1:0]       pending,
  input  logic [LANES-1:0]       lead_oh,
  output logic [TAG_W-1:0]       lead_tag,
  output logic [LANES-1:0]       hit
);
  always_comb begin
    lead_tag = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lead_oh[i]) lead_tag = lead_tag | tags[i*TAG_W +: TAG_W];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign hit[g] = pending[g] && (tags[g*TAG_W +: TAG_W] == lead_tag);
  end
endmodule

// File: rtl/wlc_warp_store.sv
// Holds the line tags, warp id and unserved-lane mask of the warp in flight.
module wlc_warp_store #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7,
  parameter int WID_W  = 6,
  localparam int TAG_W = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    consume,
  input  logic [LANES*ADDR_W-1:0] new_addr,
  input  logic [LANES-1:0]        new_mask,
  input  logic [WID_W-1:0]        new_wid,
  input  logic [LANES-1:0]        served,
  output logic [LANES*TAG_W-1:0]  tags,
  output logic [WID_W-1:0]        wid,
  output logic [LANES-1:0]        pending
);
  logic [LANES*OFF_W-1:0] unused_offset_bits;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // Only the line part of each address is kept; the byte offset is dropped.
    assign unused_offset_bits[g*OFF_W +: OFF_W] = new_addr[g*ADDR_W +: OFF_W];
    always_ff @(posedge clk) begin
      if (load) tags[g*TAG_W +: TAG_W] <= new_addr[g*ADDR_W+OFF_W +: TAG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
      wid     <= '0;
    end else if (load) begin
      pending <= new_mask;
      wid     <= new_wid;
    end else if (consume) begin
      pending <= pending & ~served;
    end
  end
endmodule

// File: rtl/warp_line_coalescer.sv
module warp_line_coalescer
  import wlc_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int WID_W      = 6,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WID_W-1:0]        in_wid,
  input  logic [LANES-1:0]        in_mask,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [TAG_W-1:0]        out_line,
  output logic [WID_W-1:0]        out_wid,
  output logic [LANES-1:0]        out_lanes
);
  logic [LANES*TAG_W-1:0] tags;
  logic [LANES-1:0]       pending;
  logic [LANES-1:0]       lead_oh;
  logic [LANES-1:0]       hit;
  logic [TAG_W-1:0]       lead_tag;
  logic [WID_W-1:0]       held_wid;
  logic                   take_out;
  logic                   take_in;
  wlc_step_e              step;

  wlc_warp_store #(
    .LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WID_W(WID_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .load(take_in), .consume(take_out),
    .new_addr(in_addr), .new_mask(in_mask), .new_wid(in_wid),
    .served(hit),
    .tags(tags), .wid(held_wid), .pending(pending)
  );

  wlc_leader #(.LANES(LANES)) u_leader (
    .pending(pending), .lead_oh(lead_oh)
  );

  wlc_line_cmp #(.LANES(LANES), .TAG_W(TAG_W)) u_cmp (
    .tags(tags), .pending(pending), .lead_oh(lead_oh),
    .lead_tag(lead_tag), .hit(hit)
  );

  always_comb begin
    if (pending == '0)                step = STEP_IDLE;
    else if ((pending & ~hit) == '0)  step = STEP_LAST;
    else                              step = STEP_MORE;
  end

  assign out_valid = (step != STEP_IDLE);
  assign out_line  = lead_tag;
  assign out_wid   = held_wid;
  assign out_lanes = hit;
  assign take_out  = out_valid && out_ready;
  assign in_ready  = (step == STEP_IDLE) || (take_out && step == STEP_LAST);
  assign take_in   = in_valid && in_ready;
endmodule

// File: rtl/wlc_checker.sv
module wlc_checker #(
  parameter int LANES = 32,
  parameter int TAG_W = 25,
  parameter int WID_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LANES-1:0] in_mask,
  input logic             out_valid,
  input logic             out_ready,
  input logic [TAG_W-1:0] out_line,
  input logic [WID_W-1:0] out_wid,
  input logic [LANES-1:0] out_lanes
);
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_line)
                                   && $stable(out_lanes) && $stable(out_wid)));

  a_r8_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r4_lanes_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_lanes != '0));

  a_r4_disjoint_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !(in_valid && in_ready))
      |=> ((out_lanes & $past(out_lanes)) == '0));

  a_r6_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mask != '0) |=> out_valid);

  a_r9_empty_warp_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mask == '0) |=> !out_valid);
endmodule

bind warp_line_coalescer wlc_checker #(
  .LANES(LANES), .TAG_W(TAG_W), .WID_W(WID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_ready(in_ready), .in_mask(in_mask),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_line(out_line), .out_wid(out_wid), .out_lanes(out_lanes)
);

// File: tb/tb_warp_line_coalescer.sv
module tb_warp_line_coalescer;
  localparam int LANES      = 8;
  localparam int ADDR_W     = 12;
  localparam int LINE_BYTES = 16;
  localparam int WID_W      = 4;
  localparam int OFF_W      = 4;
  localparam int TAG_W      = ADDR_W - OFF_W;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic [WID_W-1:0]        in_wid = '0;
  logic [LANES-1:0]        in_mask = '0;
  logic [LANES*ADDR_W-1:0] in_addr = '0;
  logic                    out_valid;
  logic                    out_ready = 1'b0;
  logic [TAG_W-1:0]        out_line;
  logic [WID_W-1:0]        out_wid;
  logic [LANES-1:0]        out_lanes;

  int unsigned vectors = 0;
  int unsigned errors  = 0;
  bit          reported = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  logic [ADDR_W-1:0] addr [LANES];

  always #4 clk = ~clk;

  warp_line_coalescer #(
    .LANES(LANES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WID_W(WID_W)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_wid(in_wid),
    .in_mask(in_mask), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_line(out_line), .out_wid(out_wid), .out_lanes(out_lanes)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    end
  endtask

  task automatic drive_addr();
    for (int i = 0; i < LANES; i++) in_addr[i*ADDR_W +: ADDR_W] = addr[i];
  endtask

  // Offer a warp while idle; called just after a rising edge.
  task automatic send(input logic [LANES-1:0] m, input logic [WID_W-1:0] w);
    in_valid = 1'b1;
    in_mask  = m;
    in_wid   = w;
    drive_addr();
    #1;
    chk("R8 in_ready idle", in_ready, 1'b1);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Reference model: lowest unserved lane leads, all same-line lanes join.
  task automatic drain(input logic [LANES-1:0] m, input logic [WID_W-1:0] w);
    logic [LANES-1:0] rem;
    logic [LANES-1:0] lanes;
    logic [TAG_W-1:0] ltag;
    logic             last;
    logic             rdy;
    int               lead;
    rem = m;
    while (rem != '0) begin
      lead = -1;
      for (int i = LANES - 1; i >= 0; i--) if (rem[i]) lead = i;
      ltag  = TAG_W'(addr[lead] >> OFF_W);
      lanes = '0;
      for (int i = 0; i < LANES; i++)
        if (rem[i] && TAG_W'(addr[i] >> OFF_W) == ltag) lanes[i] = 1'b1;
      last = ((rem & ~lanes) == '0);
      do begin
        rdy = (rnd() % 3) != 0;
        out_ready = rdy;
        #1;
        chk("R6 out_valid", out_valid, 1'b1);
        chk("R2/R7 out_line", out_line, ltag);
        chk("R3/R10 out_lanes", out_lanes, lanes);
        chk("R5 out_wid", out_wid, w);
        chk("R8 in_ready drain", in_ready, rdy && last);
        @(posedge clk); #1;
      end while (!rdy);
      rem = rem & ~lanes;
    end
    out_ready = 1'b0;
    #1;
    chk("R4 warp done", out_valid, 1'b0);
    chk("R8 in_ready after", in_ready, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < LANES; i++) addr[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 out_valid", out_valid, 1'b0);
    chk("R1 in_ready", in_ready, 1'b1);

    // R4: all lanes on one line -> a single request
    for (int i = 0; i < LANES; i++) addr[i] = ADDR_W'(12'h340 + i);
    send('1, 4'd3);
    drain('1, 4'd3);

    // R4: every lane on its own line, descending order -> LANES requests
    for (int i = 0; i < LANES; i++) addr[i] = ADDR_W'((LANES - i) * LINE_BYTES + 3);
    send('1, 4'd9);
    drain('1, 4'd9);

    // R8: last line leaves while the next warp is offered in the same cycle
    for (int i = 0; i < LANES; i++) addr[i] = ADDR_W'(12'h100 + i * 40);
    send(8'b0000_0100, 4'd1);
    out_ready = 1'b1;
    for (int i = 0; i < LANES; i++) addr[i] = ADDR_W'(12'h800 + (i % 3) * LINE_BYTES + i);
    in_valid = 1'b1;
    in_mask  = 8'b1011_0110;
    in_wid   = 4'd12;
    drive_addr();
    #1;
    chk("R3 single lane", out_lanes, 8'b0000_0100);
    chk("R8 in_ready on last take", in_ready, 1'b1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    drain(8'b1011_0110, 4'd12);

    // R9: empty mask accepted, no request
    for (int i = 0; i < LANES; i++) addr[i] = ADDR_W'(rnd());
    send('0, 4'd7);
    #1;
    chk("R9 no request", out_valid, 1'b0);
    chk("R9 still ready", in_ready, 1'b1);

    // Sweep of every mask; inactive lanes carry random addresses (R10).
    for (int m = 0; m < (1 << LANES); m++) begin
      for (int i = 0; i < LANES; i++) begin
        logic [31:0] r;
        r = rnd();
        addr[i] = ADDR_W'((m % 8) * 64 + ((r >> 8) % 4) * LINE_BYTES + (r % LINE_BYTES));
      end
      send(LANES'(m), WID_W'(m));
      if (m == 0) begin
        #1;
        chk("R9 sweep empty", out_valid, 1'b0);
      end else begin
        drain(LANES'(m), WID_W'(m));
      end
    end

    report();
    $finish;
  end
endmodule